// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits on the request/response bus between a processor's load/store port and one memory device. It gives that memory load-reserved and store-conditional word semantics. Each request carries a flag that marks it as a reservation operation. A flagged read goes to memory unchanged and also arms a single reservation on the word it touched. A flagged write is a conditional store. It reaches memory only while that reservation is still armed. Its outcome returns to the processor in bit 0 of the response data.

Unflagged accesses, fence pulses and the source and privilege attributes pass straight through to memory. When the reservation is not armed, the monitor drops the conditional store before it reaches memory. It then answers the processor itself, one cycle later. A plain write to the reserved word breaks the reservation, whatever its source, privilege or byte lanes. The word-address width and data width are parameters.

Top module: `rsv_guard`

## Requirements
- R1: After reset no reservation is armed, so a conditional store issued before any reserved read fails and leaves memory unchanged.
- R2: A reserved read (direction 0, flag 1) is forwarded to memory, its response data is returned unchanged, and it arms the reservation on its word address.
- R3: A conditional store (direction 1, flag 1) issued while the reservation is armed is forwarded to memory, and its response data is all zeros (bit 0 = 0 means success).
- R4: A conditional store issued while no reservation is armed raises no memory strobe. The monitor acknowledges it one cycle after the request, with response data 1 (bit 0 = 1 means failure) and error low.
- R5: Every conditional store disarms the reservation, whether it succeeded or failed, so a second store without a new reserved read fails.
- R6: A new reserved read replaces the previous reservation. A later write to the old word no longer affects the new one.
- R7: Any write to the reserved word disarms the reservation, including a single-byte write at a non-zero byte offset. Words are compared on address bits above the byte offset. A write to a different word leaves the reservation armed.
- R8: Plain reads and fence pulses (fence high with strobe low) leave the reservation unchanged. The fence bit is passed to memory even without a strobe.
- R9: Unflagged accesses pass through with address, data, byte enables, direction, source, privilege and fence unchanged, and their responses pass back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_stb | input | 1 | Request strobe, one cycle per access |
| cpu_req_rw | input | 1 | Direction: 0 read, 1 write |
| cpu_req_src | input | 1 | Source: 0 instruction fetch, 1 load/store |
| cpu_req_priv | input | 1 | Privileged access |
| cpu_req_rsv | input | 1 | Reservation-operation flag |
| cpu_req_fence | input | 1 | Fence pulse, valid without strobe |
| cpu_req_addr | input | AW | Byte address |
| cpu_req_wdata | input | DW | Write data |
| cpu_req_ben | input | DW/8 | Byte enables |
| cpu_rsp_ack | output | 1 | Response acknowledge |
| cpu_rsp_err | output | 1 | Response error |
| cpu_rsp_rdata | output | DW | Response read data or store status |
| mem_req_stb | output | 1 | Strobe toward memory |
| mem_req_rw | output | 1 | Direction toward memory |
| mem_req_src | output | 1 | Source toward memory |
| mem_req_priv | output | 1 | Privilege toward memory |
| mem_req_fence | output | 1 | Fence toward memory |
| mem_req_addr | output | AW | Address toward memory |
| mem_req_wdata | output | DW | Write data toward memory |
| mem_req_ben | output | DW/8 | Byte enables toward memory |
| mem_rsp_ack | input | 1 | Memory acknowledge |
| mem_rsp_err | input | 1 | Memory error |
| mem_rsp_rdata | input | DW | Memory read data |

## Verification
The hardest case to reach is a reservation broken by a narrow write inside the reserved word. No output shows the break directly. It only appears when a later conditional store fails and the memory content stays the same. The stimulus reserves a word and writes one byte at offset 3 of that word. It then issues the conditional store, checks for the failure code, and reads the word back to confirm that only the byte write landed. Replacement of one reservation by another is reached the same way: reserve word A, reserve word B, write A, then store conditionally to B.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      ACC_PLAIN = 2'd0,
      ACC_LR    = 2'd1,
      ACC_SC    = 2'd2
   } acc_kind_e;

   function automatic acc_kind_e acc_kind(input logic stb, input logic rw, input logic rsv);
      if (stb && rsv && !rw) return ACC_LR;
      if (stb && rsv && rw)  return ACC_SC;
      return ACC_PLAIN;
   endfunction

endpackage

// File: rtl/rsv_track.sv
module rsv_track #(
   parameter int AW  = 32,
   parameter int OFS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_stb,
   input  logic          req_rw,
   input  logic          req_rsv,
   input  logic [AW-1:0] req_addr,
   output logic          rsv_valid,
   output logic [AW-OFS-1:0] rsv_tag
);
   localparam int TW = AW - OFS;

   logic [TW-1:0] word_idx;
   logic          wr_hit;

   generate
      if (OFS > 0) begin : g_slice
         assign word_idx = req_addr[AW-1:OFS];
      end else begin : g_whole
         assign word_idx = req_addr;
      end
   endgenerate

   assign wr_hit = req_stb && req_rw && rsv_valid && (word_idx == rsv_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsv_valid <= 1'b0;
         rsv_tag   <= '0;
      end else if (req_stb && req_rsv && !req_rw) begin
         rsv_valid <= 1'b1;
         rsv_tag   <= word_idx;
      end else if (req_stb && req_rw && (req_rsv || wr_hit)) begin
         rsv_valid <= 1'b0;
      end
   end

   // R2: a reserved read arms the reservation on its word
   assert_lr_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stb && req_rsv && !req_rw) |=> (rsv_valid && rsv_tag == $past(word_idx)));

   // R7: a write to the reserved word disarms it
   assert_hit_breaks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stb && req_rw && rsv_valid && word_idx == rsv_tag) |=> !rsv_valid);

   // R8: cycles without strobe (fence pulses included) keep the reservation
   assert_idle_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_stb) |=> ($stable(rsv_valid) && $stable(rsv_tag)));

   // R5: every conditional store disarms the reservation
   assert_sc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stb && req_rsv && req_rw) |=> !rsv_valid);
endmodule

// File: rtl/rsv_gate.sv
module rsv_gate
   import rsv_pkg::*;
(
   input  logic req_stb,
   input  logic req_rw,
   input  logic req_rsv,
   input  logic rsv_valid,
   output logic mem_stb,
   output logic sc_fail,
   output logic sc_pass
);
   acc_kind_e kind;

   always_comb begin
      kind    = acc_kind(req_stb, req_rw, req_rsv);
      sc_pass = (kind == ACC_SC) && rsv_valid;
      sc_fail = (kind == ACC_SC) && !rsv_valid;
      mem_stb = req_stb && !sc_fail;
   end
endmodule

// File: rtl/rsv_resp.sv
module rsv_resp #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sc_fail,
   input  logic          sc_pass,
   input  logic          mem_ack,
   input  logic          mem_err,
   input  logic [DW-1:0] mem_rdata,
   output logic          cpu_ack,
   output logic          cpu_err,
   output logic [DW-1:0] cpu_rdata
);
   logic fail_q;
   logic pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_q <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         fail_q <= sc_fail;
         if (sc_pass)      pass_q <= 1'b1;
         else if (mem_ack) pass_q <= 1'b0;
      end
   end

   always_comb begin
      cpu_ack = mem_ack || fail_q;
      cpu_err = fail_q ? 1'b0 : mem_err;
      if (fail_q)      cpu_rdata = {{(DW-1){1'b0}}, 1'b1};
      else if (pass_q) cpu_rdata = '0;
      else             cpu_rdata = mem_rdata;
   end

   // R4: the locally generated acknowledge follows the dropped store by one cycle with failure code
   assert_fail_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sc_fail |=> (cpu_ack && cpu_rdata[0] && !cpu_err));

   // R3: a forwarded conditional store returns a zero status word
   assert_pass_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_q && mem_ack) |-> (cpu_rdata == '0));
endmodule

// File: rtl/rsv_guard.sv
module rsv_guard #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_req_stb,
   input  logic            cpu_req_rw,
   input  logic            cpu_req_src,
   input  logic            cpu_req_priv,
   input  logic            cpu_req_rsv,
   input  logic            cpu_req_fence,
   input  logic [AW-1:0]   cpu_req_addr,
   input  logic [DW-1:0]   cpu_req_wdata,
   input  logic [DW/8-1:0] cpu_req_ben,
   output logic            cpu_rsp_ack,
   output logic            cpu_rsp_err,
   output logic [DW-1:0]   cpu_rsp_rdata,
   output logic            mem_req_stb,
   output logic            mem_req_rw,
   output logic            mem_req_src,
   output logic            mem_req_priv,
   output logic            mem_req_fence,
   output logic [AW-1:0]   mem_req_addr,
   output logic [DW-1:0]   mem_req_wdata,
   output logic [DW/8-1:0] mem_req_ben,
   input  logic            mem_rsp_ack,
   input  logic            mem_rsp_err,
   input  logic [DW-1:0]   mem_rsp_rdata
);
   localparam int NB  = DW / 8;
   localparam int OFS = (NB > 1) ? $clog2(NB) : 0;
   localparam int TW  = AW - OFS;

   generate
      if ((DW % 8) != 0 || DW < 8) begin : g_bad_dw
         $error("rsv_guard: DW must be a positive multiple of 8");
      end
      if ((1 << OFS) != NB) begin : g_bad_pow
         $error("rsv_guard: DW/8 must be a power of two");
      end
      if (AW <= OFS) begin : g_bad_aw
         $error("rsv_guard: AW too small for the word size");
      end
   endgenerate

   logic          rsv_valid;
   logic [TW-1:0] rsv_tag;
   logic          sc_fail;
   logic          sc_pass;

   rsv_track #(.AW(AW), .OFS(OFS)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_stb   (cpu_req_stb),
      .req_rw    (cpu_req_rw),
      .req_rsv   (cpu_req_rsv),
      .req_addr  (cpu_req_addr),
      .rsv_valid (rsv_valid),
      .rsv_tag   (rsv_tag)
   );

   rsv_gate u_gate (
      .req_stb   (cpu_req_stb),
      .req_rw    (cpu_req_rw),
      .req_rsv   (cpu_req_rsv),
      .rsv_valid (rsv_valid),
      .mem_stb   (mem_req_stb),
      .sc_fail   (sc_fail),
      .sc_pass   (sc_pass)
   );

   rsv_resp #(.DW(DW)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .sc_fail   (sc_fail),
      .sc_pass   (sc_pass),
      .mem_ack   (mem_rsp_ack),
      .mem_err   (mem_rsp_err),
      .mem_rdata (mem_rsp_rdata),
      .cpu_ack   (cpu_rsp_ack),
      .cpu_err   (cpu_rsp_err),
      .cpu_rdata (cpu_rsp_rdata)
   );

   assign mem_req_rw    = cpu_req_rw;
   assign mem_req_src   = cpu_req_src;
   assign mem_req_priv  = cpu_req_priv;
   assign mem_req_fence = cpu_req_fence;
   assign mem_req_addr  = cpu_req_addr;
   assign mem_req_wdata = cpu_req_wdata;
   assign mem_req_ben   = cpu_req_ben;

   // R1/R4: a conditional store with no armed reservation never strobes memory
   assert_no_mem_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_stb && cpu_req_rsv && cpu_req_rw && !rsv_valid) |-> !mem_req_stb);

   // R9: unflagged strobes always reach memory
   assert_plain_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_stb && !cpu_req_rsv) |-> mem_req_stb);
endmodule

// File: tb/sim_rsv_guard.sv
module sim_rsv_guard;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_LR = 3'd2, OP_SC = 3'd3, OP_FN = 3'd4;
   localparam int NV = 23;
   // {op, byte address, write data, expected response data}
   localparam logic [74:0] VECS [0:NV-1] = '{
      {OP_LD, 8'h08, 32'h0,        32'h1000_0002},  // R9 plain load
      {OP_SC, 8'h08, 32'h0000_AAAA, 32'h1},         // R1 store before any reservation
      {OP_LD, 8'h08, 32'h0,        32'h1000_0002},  // R1 memory unchanged
      {OP_LR, 8'h08, 32'h0,        32'h1000_0002},  // R2
      {OP_SC, 8'h08, 32'h0000_AAAA, 32'h0},         // R3 success
      {OP_LD, 8'h08, 32'h0,        32'h0000_AAAA},  // R3 data written
      {OP_SC, 8'h08, 32'h0000_BBBB, 32'h1},         // R5 second store fails
      {OP_LD, 8'h08, 32'h0,        32'h0000_AAAA},  // R5 unchanged
      {OP_LR, 8'h10, 32'h0,        32'h1000_0004},  // R2
      {OP_ST, 8'h14, 32'h0000_5555, 32'h0},         // R7 other word
      {OP_SC, 8'h10, 32'h0000_CCCC, 32'h0},         // R7 still armed
      {OP_LR, 8'h10, 32'h0,        32'h0000_CCCC},  // R2
      {OP_ST, 8'h10, 32'h0000_7777, 32'h0},         // R7 hit
      {OP_SC, 8'h10, 32'h0000_DDDD, 32'h1},         // R7 broken
      {OP_LD, 8'h10, 32'h0,        32'h0000_7777},  // R7 memory keeps plain write
      {OP_LR, 8'h0C, 32'h0,        32'h1000_0003},  // R6 first
      {OP_LR, 8'h18, 32'h0,        32'h1000_0006},  // R6 replaces
      {OP_ST, 8'h0C, 32'h0000_1111, 32'h0},         // R6 old word write
      {OP_SC, 8'h18, 32'h0000_2222, 32'h0},         // R6 new still armed
      {OP_LR, 8'h20, 32'h0,        32'h1000_0008},  // R8
      {OP_LD, 8'h20, 32'h0,        32'h1000_0008},  // R8 plain read
      {OP_FN, 8'h00, 32'h0,        32'h0},          // R8 fence pulse
      {OP_SC, 8'h20, 32'h0000_3333, 32'h0}          // R8 still armed
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic c_stb = 0, c_rw = 0, c_src = 1, c_priv = 0, c_rsv = 0, c_fence = 0;
   logic [AW-1:0] c_addr = '0;
   logic [DW-1:0] c_wdata = '0;
   logic [3:0]    c_ben = '0;
   logic          r_ack, r_err;
   logic [DW-1:0] r_rdata;
   logic m_stb, m_rw, m_src, m_priv, m_fence;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata;
   logic [3:0]    m_ben;
   logic          m_ack;
   logic [DW-1:0] m_rdata;
   logic [DW-1:0] mem [0:15];
   int            mem_writes;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsv_guard #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_stb(c_stb), .cpu_req_rw(c_rw), .cpu_req_src(c_src), .cpu_req_priv(c_priv),
      .cpu_req_rsv(c_rsv), .cpu_req_fence(c_fence), .cpu_req_addr(c_addr),
      .cpu_req_wdata(c_wdata), .cpu_req_ben(c_ben),
      .cpu_rsp_ack(r_ack), .cpu_rsp_err(r_err), .cpu_rsp_rdata(r_rdata),
      .mem_req_stb(m_stb), .mem_req_rw(m_rw), .mem_req_src(m_src), .mem_req_priv(m_priv),
      .mem_req_fence(m_fence), .mem_req_addr(m_addr), .mem_req_wdata(m_wdata),
      .mem_req_ben(m_ben),
      .mem_rsp_ack(m_ack), .mem_rsp_err(1'b0), .mem_rsp_rdata(m_rdata)
   );

   // memory model: one-cycle acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 32'h1000_0000 + i;
         m_ack <= 1'b0;
         m_rdata <= '0;
         mem_writes <= 0;
      end else begin
         m_ack <= m_stb;
         m_rdata <= m_stb ? mem[m_addr[5:2]] : '0;
         if (m_stb && m_rw) begin
            mem_writes <= mem_writes + 1;
            for (int b = 0; b < 4; b++)
               if (m_ben[b]) mem[m_addr[5:2]][8*b +: 8] <= m_wdata[8*b +: 8];
         end
      end
   end

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [2:0] op, input logic [7:0] a, input logic [DW-1:0] wd,
                      input logic [3:0] be, output logic [DW-1:0] rd, output logic got);
      @(negedge clk);
      c_stb = 1'b1; c_addr = {24'h0, a}; c_wdata = wd; c_ben = be;
      c_rw = (op == OP_ST || op == OP_SC);
      c_rsv = (op == OP_LR || op == OP_SC);
      @(negedge clk);
      c_stb = 1'b0; c_rsv = 1'b0; c_rw = 1'b0;
      got = 1'b0; rd = '0;
      for (int w = 0; w < 20 && !got; w++) begin
         if (r_ack) begin got = 1'b1; rd = r_rdata; end
         else @(negedge clk);
      end
   endtask

   initial begin
      logic [DW-1:0] rd;
      logic got;
      int wr0;
      repeat (3) @(negedge clk);
      // reset state
      check("R1 reset ack", {31'h0, r_ack}, 32'h0);
      check("R1 reset mem strobe", {31'h0, m_stb}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] op;
         op = VECS[i][74:72];
         if (op == OP_FN) begin
            @(negedge clk);
            c_fence = 1'b1;
            #1 check("R8 fence forwarded", {31'h0, m_fence}, 32'h1);
            check("R8 fence no strobe", {31'h0, m_stb}, 32'h0);
            @(negedge clk);
            c_fence = 1'b0;
         end else begin
            wr0 = mem_writes;
            acc(op, VECS[i][71:64], VECS[i][63:32], 4'hF, rd, got);
            if (!got) begin
               errors++;
               $display("FAIL vector %0d no acknowledge actual=0 expected=1", i);
            end else if (op != OP_ST) begin
               check($sformatf("vector %0d response", i), rd, VECS[i][31:0]);
            end
            if (op == OP_SC && VECS[i][0])
               check("R4 no memory write on failure", mem_writes - wr0, 32'h0);
         end
      end

      // R7: single byte write at offset 3 inside the reserved word
      acc(OP_LR, 8'h24, 32'h0, 4'hF, rd, got);
      check("R2 reserve 0x24", rd, 32'h1000_0009);
      acc(OP_ST, 8'h27, 32'hEE00_0000, 4'h8, rd, got);
      acc(OP_SC, 8'h24, 32'h4444_4444, 4'hF, rd, got);
      check("R7 byte write breaks", rd, 32'h1);
      acc(OP_LD, 8'h24, 32'h0, 4'hF, rd, got);
      check("R7 byte landed only", rd, 32'hEE00_0009);

      // R4: failure acknowledge timing and memory strobe
      @(negedge clk);
      c_stb = 1'b1; c_rw = 1'b1; c_rsv = 1'b1; c_addr = 32'h28; c_wdata = 32'h9; c_ben = 4'hF;
      #1 check("R4 strobe suppressed", {31'h0, m_stb}, 32'h0);
      @(negedge clk);
      c_stb = 1'b0; c_rw = 1'b0; c_rsv = 1'b0;
      check("R4 ack next cycle", {31'h0, r_ack}, 32'h1);
      check("R4 error low", {31'h0, r_err}, 32'h0);
      @(negedge clk);
      check("R4 single ack", {31'h0, r_ack}, 32'h0);

      // R9: attribute pass-through with privilege and fetch source
      @(negedge clk);
      c_stb = 1'b1; c_src = 1'b0; c_priv = 1'b1; c_addr = 32'h0000_0030; c_ben = 4'h5;
      c_wdata = 32'h1234_5678; c_rw = 1'b0;
      #1 check("R9 src", {31'h0, m_src}, 32'h0);
      check("R9 priv", {31'h0, m_priv}, 32'h1);
      check("R9 addr", m_addr, 32'h30);
      check("R9 ben", {28'h0, m_ben}, 32'h5);
      check("R9 wdata", m_wdata, 32'h1234_5678);
      @(negedge clk);
      c_stb = 1'b0; c_src = 1'b1; c_priv = 1'b0;
      check("R9 read data", r_rdata, 32'h1000_000C);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule